// File: doc/BRIEF.md
# DDR PHY Power-Up Sequencer

This block steps a DDR PHY through its power-up order after a single start pulse. While static configuration is being written into the PHY, it holds the PHY in soft reset with its DLL in standby. It then takes the DLL out of standby and releases the soft reset. Next it pulses the read and write FIFO pointer initialisation and starts impedance calibration. It then waits for the DLL to report lock, and after that for calibration to report completion. Only then does it enable the address and command drivers. After a fixed settling time it raises done.

A sibling controller uses `done_o` as its cue to start. Once the controller is running, a separate write-levelling request latches the write-levelling start output. All delays are counted in clock cycles. `CLK_MHZ` converts microseconds to cycles, so the settle time is `SETTLE_US*CLK_MHZ` cycles. `CFG_CYCLES` sets the length of the configuration window. A non-zero `TIMEOUT_CYC` bounds each status wait and sends the sequencer to a sticky fault state.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is low, and on the first cycle after reset, `phy_rst_n_o` is 0 and `dll_stby_o` is 1. `cfg_window_o`, `fifo_rd_init_o`, `fifo_wr_init_o`, `cal_start_o`, `adcmd_oe_o`, `wl_start_o`, `done_o` and `err_o` are all 0.
- R2: A start pulse sampled in the idle state opens `cfg_window_o` for exactly `CFG_CYCLES` cycles. During this window `phy_rst_n_o` stays 0 and `dll_stby_o` stays 1.
- R3: `dll_stby_o` falls on the same edge that closes the configuration window. `phy_rst_n_o` rises exactly one cycle later.
- R4: One cycle after `phy_rst_n_o` rises, `fifo_rd_init_o` and `fifo_wr_init_o` are both high for exactly one cycle.
- R5: `cal_start_o` rises on the cycle after the FIFO pulse and then stays high.
- R6: The sequencer first waits for `dll_lock_i` and only afterwards samples `cal_done_i`. A `cal_done_i` pulse that ends before lock is seen does not count. `adcmd_oe_o` rises on the edge that samples `cal_done_i` high after lock was seen.
- R7: `done_o` rises exactly `SETTLE_US*CLK_MHZ` cycles after `adcmd_oe_o` rises.
- R8: `wl_start_o` rises one cycle after `wl_req_i` is sampled high while `done_o` is high. A `wl_req_i` before done has no effect.
- R9: With `TIMEOUT_CYC` non-zero, `err_o` rises `TIMEOUT_CYC` cycles after entering either status wait if the awaited status never arrives. The fault then holds until reset: `adcmd_oe_o` and `done_o` stay 0 even if the status arrives later.
- R10: A start pulse is ignored once the sequence has left the idle state.
- R11: `phy_rst_n_o`, `cal_start_o`, `adcmd_oe_o`, `done_o`, `wl_start_o` and `err_o` stay set until reset once they are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| dll_lock_i | input | 1 | DLL locked status from the PHY |
| cal_done_i | input | 1 | Impedance calibration finished status |
| wl_req_i | input | 1 | Request to start write levelling |
| cfg_window_o | output | 1 | High while static configuration may be written |
| dll_stby_o | output | 1 | DLL standby control, 1 = standby |
| phy_rst_n_o | output | 1 | PHY soft reset, active low |
| fifo_rd_init_o | output | 1 | One-cycle read FIFO pointer initialisation |
| fifo_wr_init_o | output | 1 | One-cycle write FIFO pointer initialisation |
| cal_start_o | output | 1 | Impedance calibration run enable |
| adcmd_oe_o | output | 1 | Address and command output enable |
| wl_start_o | output | 1 | Write-levelling start |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Status wait timed out |

## Verification
The hardest case to reach is a calibration-done indication that arrives before the DLL lock. The sequencer must drop that early indication and not open the output drivers. To set this up, the stimulus parks the sequencer in the lock wait and pulses `cal_done_i` alone. It then raises lock and holds calibration low for several cycles while checking that the drivers stay off. The two timeout paths are reached by withholding one status at a time with a short `TIMEOUT_CYC`. After each fault the missing status is supplied late, to show that the fault state does not resume the sequence.

// File: rtl/phy_bringup_pkg.sv
// Package: shared state encoding and control-word type for the PHY
// power-up sequencer. Assumes the state order below is the order of the
// sequence; the decode relies on that ordering.
package phy_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_CONFIG    = 4'd1,
        ST_DLL_REL   = 4'd2,
        ST_RST_REL   = 4'd3,
        ST_FIFO_INIT = 4'd4,
        ST_WAIT_LOCK = 4'd5,
        ST_WAIT_CAL  = 4'd6,
        ST_SETTLE    = 4'd7,
        ST_DONE      = 4'd8,
        ST_FAULT     = 4'd9
    } seq_state_t;

    typedef struct packed {
        logic cfg_window;
        logic dll_stby;
        logic phy_rst_n;
        logic fifo_rd;
        logic fifo_wr;
        logic cal_start;
        logic adcmd_oe;
        logic done;
        logic err;
    } seq_ctl_t;

    // Control levels that hold while the sequencer sits in state s.
    function automatic seq_ctl_t ctl_decode(seq_state_t s);
        seq_ctl_t c;
        c.cfg_window = (s == ST_CONFIG);
        c.dll_stby   = (s == ST_IDLE) || (s == ST_CONFIG);
        c.phy_rst_n  = (s >= ST_RST_REL);
        c.fifo_rd    = (s == ST_FIFO_INIT);
        c.fifo_wr    = (s == ST_FIFO_INIT);
        c.cal_start  = (s >= ST_WAIT_LOCK);
        c.adcmd_oe   = (s == ST_SETTLE) || (s == ST_DONE);
        c.done       = (s == ST_DONE);
        c.err        = (s == ST_FAULT);
        return c;
    endfunction

endpackage

// File: rtl/phy_bringup_timer.sv
// Module: loadable down-counter shared by every timed step of the sequencer.
// Loading N-1 on entry to a state keeps the state for N cycles, with
// zero_o high on the last one. Assumes only one timed step runs at a time.
module phy_bringup_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load a new interval or count down toward zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/phy_bringup_fsm.sv
// Module: power-up state machine. It walks the fixed order: configuration,
// DLL release, reset release, FIFO init, calibration, lock wait, calibration
// wait, settle, done. Control outputs are registered from the next-state
// decode, so each one changes on the edge where its state is entered.
// Assumes the status inputs are already synchronous to clk.
module phy_bringup_fsm
    import phy_bringup_pkg::*;
#(
    parameter int           TW        = 16,
    parameter logic [TW-1:0] CFG_LD    = '0,
    parameter logic [TW-1:0] SETTLE_LD = '0,
    parameter logic [TW-1:0] TO_LD     = '0,
    parameter bit           HAS_TO    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dll_lock_i,
    input  logic          cal_done_i,
    input  logic          wl_req_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output seq_ctl_t      ctl_o,
    output logic          wl_start_o
);

    seq_state_t state_q, state_d;
    seq_ctl_t   ctl_q;
    logic       wl_q;
    logic       to_hit;

    // A timeout only exists when the parameter asks for one.
    generate
        if (HAS_TO) begin : g_to
            assign to_hit = tmr_zero_i;
        end else begin : g_no_to
            assign to_hit = 1'b0;
        end
    endgenerate

    // Next state and timer load for each step of the sequence.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_CONFIG;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CFG_LD;
                end
            end
            ST_CONFIG: begin
                if (tmr_zero_i) state_d = ST_DLL_REL;
            end
            ST_DLL_REL: state_d = ST_RST_REL;
            ST_RST_REL: state_d = ST_FIFO_INIT;
            ST_FIFO_INIT: begin
                state_d    = ST_WAIT_LOCK;
                tmr_load_o = 1'b1;
                tmr_val_o  = TO_LD;
            end
            ST_WAIT_LOCK: begin
                if (dll_lock_i) begin
                    state_d    = ST_WAIT_CAL;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TO_LD;
                end else if (to_hit) begin
                    state_d = ST_FAULT;
                end
            end
            ST_WAIT_CAL: begin
                if (cal_done_i) begin
                    state_d    = ST_SETTLE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SETTLE_LD;
                end else if (to_hit) begin
                    state_d = ST_FAULT;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero_i) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_DONE;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, registered control word and the sticky write-levelling start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= ctl_decode(ST_IDLE);
            wl_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_decode(state_d);
            if ((state_q == ST_DONE) && wl_req_i) wl_q <= 1'b1;
        end
    end

    assign ctl_o      = ctl_q;
    assign wl_start_o = wl_q;

endmodule

// File: rtl/phy_bringup_seq.sv
// Module: top of the DDR PHY power-up sequencer. It turns microsecond and
// cycle parameters into timer load values and wires the state machine to
// the shared down-counter. Assumes CLK_MHZ is the clk frequency in MHz and
// that CFG_CYCLES and SETTLE_US*CLK_MHZ are both at least 1.
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int SETTLE_US   = 200,
    parameter int CFG_CYCLES  = 16,
    parameter int TIMEOUT_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dll_lock_i,
    input  logic cal_done_i,
    input  logic wl_req_i,
    output logic cfg_window_o,
    output logic dll_stby_o,
    output logic phy_rst_n_o,
    output logic fifo_rd_init_o,
    output logic fifo_wr_init_o,
    output logic cal_start_o,
    output logic adcmd_oe_o,
    output logic wl_start_o,
    output logic done_o,
    output logic err_o
);

    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int MAX_AB     = (SETTLE_CYC > CFG_CYCLES) ? SETTLE_CYC : CFG_CYCLES;
    localparam int MAX_CYC    = (TIMEOUT_CYC > MAX_AB) ? TIMEOUT_CYC : MAX_AB;
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam bit HAS_TO     = (TIMEOUT_CYC != 0);
    localparam logic [TW-1:0] CFG_LD    = TW'(CFG_CYCLES - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] TO_LD     = HAS_TO ? TW'(TIMEOUT_CYC - 1) : '0;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    seq_ctl_t      ctl;

    phy_bringup_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    phy_bringup_fsm #(
        .TW        (TW),
        .CFG_LD    (CFG_LD),
        .SETTLE_LD (SETTLE_LD),
        .TO_LD     (TO_LD),
        .HAS_TO    (HAS_TO)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dll_lock_i (dll_lock_i),
        .cal_done_i (cal_done_i),
        .wl_req_i   (wl_req_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .ctl_o      (ctl),
        .wl_start_o (wl_start_o)
    );

    assign cfg_window_o   = ctl.cfg_window;
    assign dll_stby_o     = ctl.dll_stby;
    assign phy_rst_n_o    = ctl.phy_rst_n;
    assign fifo_rd_init_o = ctl.fifo_rd;
    assign fifo_wr_init_o = ctl.fifo_wr;
    assign cal_start_o    = ctl.cal_start;
    assign adcmd_oe_o     = ctl.adcmd_oe;
    assign done_o         = ctl.done;
    assign err_o          = ctl.err;

endmodule

// File: rtl/phy_bringup_seq_chk.sv
// Module: assertion checker for the power-up sequencer. It sees only the
// top-level ports and keeps two small trackers of its own: whether lock has
// been seen, and how many cycles have passed since the output enable.
module phy_bringup_seq_chk #(
    parameter int SETTLE_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic dll_lock_i,
    input logic cal_done_i,
    input logic wl_req_i,
    input logic cfg_window_o,
    input logic dll_stby_o,
    input logic phy_rst_n_o,
    input logic fifo_rd_init_o,
    input logic fifo_wr_init_o,
    input logic cal_start_o,
    input logic adcmd_oe_o,
    input logic wl_start_o,
    input logic done_o,
    input logic err_o
);

    logic        lock_seen_q;
    logic [31:0] settle_cnt_q;

    // Remember that lock was reported while calibration was running.
    always_ff @(posedge clk) begin
        if (!rst_n)                        lock_seen_q <= 1'b0;
        else if (dll_lock_i && cal_start_o) lock_seen_q <= 1'b1;
    end

    // Count cycles from the output enable up to done.
    always_ff @(posedge clk) begin
        if (!rst_n || !adcmd_oe_o) settle_cnt_q <= '0;
        else if (!done_o)          settle_cnt_q <= settle_cnt_q + 1'b1;
    end

    // R2
    cfg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_window_o) |-> $past(start_i) && !phy_rst_n_o && dll_stby_o);

    // R3
    rst_after_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_n_o) |-> !dll_stby_o && $past(!dll_stby_o));

    // R4
    fifo_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_init_o |=> !fifo_rd_init_o);

    // R4
    fifo_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr_init_o) |-> $past(phy_rst_n_o) && !cal_start_o);

    // R6
    oe_after_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adcmd_oe_o) |-> $past(cal_done_i) && $past(lock_seen_q) && cal_start_o);

    // R7
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> adcmd_oe_o && (settle_cnt_q == 32'(SETTLE_CYC)));

    // R8
    wl_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_start_o) |-> done_o && $past(done_o) && $past(wl_req_i));

    // R9
    fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o && !done_o && !adcmd_oe_o);

    // R11
    sticky_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_n_o |=> phy_rst_n_o && cal_start_o == $past(cal_start_o) || cal_start_o);

endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .dll_lock_i     (dll_lock_i),
    .cal_done_i     (cal_done_i),
    .wl_req_i       (wl_req_i),
    .cfg_window_o   (cfg_window_o),
    .dll_stby_o     (dll_stby_o),
    .phy_rst_n_o    (phy_rst_n_o),
    .fifo_rd_init_o (fifo_rd_init_o),
    .fifo_wr_init_o (fifo_wr_init_o),
    .cal_start_o    (cal_start_o),
    .adcmd_oe_o     (adcmd_oe_o),
    .wl_start_o     (wl_start_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for the power-up sequencer: one task per scenario.
module phy_bringup_seq_tb;

    localparam int CLK_MHZ  = 250;
    localparam int SET_US   = 2;
    localparam int CFG_N    = 8;
    localparam int TO_N     = 64;
    localparam int SETTLE_N = SET_US * CLK_MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, lock = 1'b0, cal = 1'b0, wlreq = 1'b0;
    logic cfg_w, stby, prst_n, frd, fwr, cal_st, oe, wl_st, done, err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    phy_bringup_seq #(
        .CLK_MHZ(CLK_MHZ), .SETTLE_US(SET_US),
        .CFG_CYCLES(CFG_N), .TIMEOUT_CYC(TO_N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dll_lock_i(lock),
        .cal_done_i(cal), .wl_req_i(wlreq), .cfg_window_o(cfg_w),
        .dll_stby_o(stby), .phy_rst_n_o(prst_n), .fifo_rd_init_o(frd),
        .fifo_wr_init_o(fwr), .cal_start_o(cal_st), .adcmd_oe_o(oe),
        .wl_start_o(wl_st), .done_o(done), .err_o(err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R1: reset values
    task automatic do_reset();
        rst_n = 1'b0; start = 0; lock = 0; cal = 0; wlreq = 0;
        tick(); tick();
        chk(prst_n == 0 && stby == 1, "R1 reset rst/stby", {prst_n, stby}, 1);
        chk({cfg_w, frd, fwr, cal_st, oe, wl_st, done, err} == 8'h00,
            "R1 reset others", {cfg_w, frd, fwr, cal_st, oe, wl_st, done, err}, 0);
        rst_n = 1'b1;
        tick();
        chk(prst_n == 0 && stby == 1 && cfg_w == 0, "R1 after reset", {prst_n, stby, cfg_w}, 2);
    endtask

    // R2..R5: start and walk to the lock wait, checking each step
    task automatic run_to_lock_wait();
        int n;
        start = 1'b1; tick(); start = 1'b0;
        chk(cfg_w == 1 && prst_n == 0 && stby == 1, "R2 window open", {cfg_w, prst_n, stby}, 5);
        n = 0;
        while (cfg_w && n < 100) begin n++; tick(); end
        chk(n == CFG_N, "R2 window length", n, CFG_N);
        chk(stby == 0 && prst_n == 0, "R3 dll released first", {stby, prst_n}, 0);
        tick();
        chk(prst_n == 1 && frd == 0, "R3 reset released next", {prst_n, frd}, 2);
        tick();
        chk(frd == 1 && fwr == 1 && cal_st == 0, "R4 fifo pulse", {frd, fwr, cal_st}, 6);
        tick();
        chk(frd == 0 && fwr == 0, "R4 fifo one cycle", {frd, fwr}, 0);
        chk(cal_st == 1 && oe == 0, "R5 cal start", {cal_st, oe}, 2);
    endtask

    task automatic t_normal();
        int n;
        do_reset();
        run_to_lock_wait();
        wlreq = 1'b1; tick(); wlreq = 1'b0; tick();
        chk(wl_st == 0, "R8 early wl_req ignored", wl_st, 0);
        chk(oe == 0, "R6 no oe without lock", oe, 0);
        lock = 1'b1; tick();
        cal = 1'b1; tick();
        chk(oe == 1 && done == 0, "R6 oe after cal", {oe, done}, 2);
        n = 0;
        while (!done && n < 2000) begin tick(); n++; end
        chk(n == SETTLE_N, "R7 settle cycles", n, SETTLE_N);
        chk(wl_st == 0, "R8 no wl before request", wl_st, 0);
        wlreq = 1'b1; tick(); wlreq = 1'b0;
        chk(wl_st == 1, "R8 wl start", wl_st, 1);
        lock = 0; cal = 0;
        start = 1'b1; tick(); start = 1'b0; tick();
        chk(cfg_w == 0 && done == 1, "R10 start ignored when done", {cfg_w, done}, 1);
        chk({prst_n, cal_st, oe, done, wl_st, stby} == 6'b111110, "R11 levels held",
            {prst_n, cal_st, oe, done, wl_st, stby}, 62);
    endtask

    task automatic t_early_cal();
        do_reset();
        run_to_lock_wait();
        cal = 1'b1; tick(); cal = 1'b0; tick();
        lock = 1'b1; tick(); tick(); tick();
        chk(oe == 0, "R6 early cal dropped", oe, 0);
        cal = 1'b1; tick();
        chk(oe == 1 && done == 0, "R6 cal after lock", {oe, done}, 2);
    endtask

    task automatic t_busy_start();
        do_reset();
        run_to_lock_wait();
        start = 1'b1; tick(); start = 1'b0; tick();
        chk(cfg_w == 0 && prst_n == 1 && stby == 0, "R10 start ignored busy",
            {cfg_w, prst_n, stby}, 2);
    endtask

    task automatic t_lock_timeout();
        int n;
        do_reset();
        run_to_lock_wait();
        n = 0;
        while (!err && n < 500) begin tick(); n++; end
        chk(n == TO_N, "R9 lock timeout", n, TO_N);
        lock = 1'b1; tick(); cal = 1'b1; tick(); tick(); tick();
        chk(err == 1 && oe == 0 && done == 0, "R9 fault holds", {err, oe, done}, 4);
    endtask

    task automatic t_cal_timeout();
        int n;
        do_reset();
        run_to_lock_wait();
        lock = 1'b1; tick();
        n = 0;
        while (!err && n < 500) begin tick(); n++; end
        chk(n == TO_N, "R9 cal timeout", n, TO_N);
        cal = 1'b1; tick(); tick();
        chk(err == 1 && oe == 0, "R9 late cal ignored", {err, oe}, 2);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        t_normal();
        t_early_cal();
        t_busy_start();
        t_lock_timeout();
        t_cal_timeout();
        summary();
        $finish;
    end

endmodule